// File: doc/BRIEF.md
# Capture/Reload Timer Group

The block holds three up/down counters of the same width: one main counter and two helper counters. Any counter whose helper role is "plain counter" picks one of three count sources: a tick from a prescaled system clock, the same tick qualified by the level of its input pin, or edges on its input pin. The counting direction is a control bit. When enabled, a synchronized direction pin can invert it. The main counter owns a toggle bit that flips each time the counter passes its top or bottom value. The toggle bit drives an output pin.

A helper counter can take one of two other roles, and in either role it no longer counts. As a capture register, an edge on its pin copies the main count into it. As a reload source, a selected flip direction of the toggle bit loads its value into the main counter in place of the wrapped value. When one helper reloads on the rising flip and the other on the falling flip, the toggle output becomes a PWM wave with separately programmed high and low times, and software does nothing once it starts. Software reaches everything through a word-wide register port with single-cycle writes and combinational reads. Event flags are sticky and are cleared by writing ones.

Register map, with i = 0 for the main counter and 1, 2 for the helpers: address 2i is the control word of counter i, address 2i+1 is its count, and address 6 holds the flags in bits [2:0] and the toggle bit in bit 8. The control word layout is: [2:0] prescale n, [4:3] source (0 tick, 1 gated tick, 2 pin edges), [6:5] edge mask (bit 5 rising, bit 6 falling), [7] gate active level, [8] count down, [9] direction pin enable, [10] run, [12:11] helper role (0 counter, 1 capture, 2 reload), [14:13] trigger mask (bit 13 rising, bit 14 falling).

Top module: `mmt_timer`

## Requirements
- R1: After reset, every control word and count reads 0, tog_o is 0 and irq_o is 0.
- R2: With source 0 and run set, a counter steps once every 8·2^n system clocks, where n is control bits [2:0]. This holds for the main counter and for a helper in the counter role.
- R3: Stepping up from all ones gives 0, and stepping down from 0 gives all ones. Each such wrap of the main counter inverts tog_o and sets flag bit 0.
- R4: With source 1, the counter steps on prescaler ticks only while its synchronized pin equals control bit 7.
- R5: With source 2, the counter steps once per synchronized pin edge that is enabled in the edge mask (bit 5 rising, bit 6 falling, both bits for both edges).
- R6: The effective direction is down when control bit 8 XOR (control bit 9 AND the synchronized direction pin) is 1.
- R7: A helper in the capture or reload role holds its count except when a write or a capture changes it.
- R8: A helper in the capture role copies the main count on a pin edge selected by trigger mask bits [14:13] (bit 13 rising, bit 14 falling) and sets its flag (bit 1 for helper 1, bit 2 for helper 2).
- R9: A helper in the reload role loads its value into the main counter on a toggle flip selected by bits [14:13] (bit 13 rise 0→1, bit 14 fall 1→0). If both helpers match, helper 1 wins.
- R10: With helper 1 reloading on the rise from value A and helper 2 on the fall from value B, and the main counter counting up at n=0, tog_o stays high for (2^16−A)·8 clocks and low for (2^16−B)·8 clocks.
- R11: Writing address 6 clears every flag whose data bit is 1 and leaves the others unchanged. A flag event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| core_pin_i | input | 1 | Main counter gate or count input |
| core_dir_i | input | 1 | Main counter direction pin |
| aux_pin_i | input | 2 | Helper gate, count or capture inputs |
| aux_dir_i | input | 2 | Helper direction pins |
| tog_o | output | 1 | Toggle bit of the main counter |
| irq_o | output | 3 | Sticky event flags |

## Verification
A stale or misrouted step shows up within one prescale period. The count read back after a whole number of periods is off by one, and tog_o or flag 0 misses a wrap or flips without one. A wrong reload source or priority skews the very next high or low time of tog_o by a multiple of 8 clocks. A helper that keeps counting in its capture role leaves a captured value that no longer matches the frozen main count on the next read. Pin paths are checked three clocks after a level change, since the synchronizer and the edge register come first.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int REG_W     = 16;
  localparam int BASE_LOG2 = 3;   // finest tick = 8 clocks
  localparam int PSC_W     = 3;
  localparam int NDIV      = 1 << PSC_W;

  typedef enum logic [1:0] {
    SRC_TICK  = 2'd0,
    SRC_GATED = 2'd1,
    SRC_EDGE  = 2'd2,
    SRC_NONE  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ROLE_COUNT   = 2'd0,
    ROLE_CAPTURE = 2'd1,
    ROLE_RELOAD  = 2'd2,
    ROLE_NONE    = 2'd3
  } role_e;

  typedef struct packed {
    logic [1:0]       trig;
    role_e            role;
    logic             run;
    logic             xdir_en;
    logic             dir_dn;
    logic             gate_hi;
    logic [1:0]       edge_msk;
    src_e             src;
    logic [PSC_W-1:0] psc;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/mmt_sync_edge.sv
module mmt_sync_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;
    assign fall_o[g] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/mmt_prescaler.sv
module mmt_prescaler
  import mmt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [NDIV-1:0] tick_o
);
  localparam int PRE_W = BASE_LOG2 + NDIV - 1;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // tick k fires once every 8*2^k clocks
  for (genvar k = 0; k < NDIV; k++) begin : g_tick
    assign tick_o[k] = &pre_q[BASE_LOG2+k-1:0];
  end
endmodule

// File: rtl/mmt_count_unit.sv
module mmt_count_unit
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [NDIV-1:0]  tick_i,
  input  logic [PSC_W-1:0] psc_i,
  input  src_e             src_i,
  input  logic [1:0]       edge_msk_i,
  input  logic             gate_hi_i,
  input  logic             dir_dn_i,
  input  logic             xdir_en_i,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             pin_lvl_i,
  input  logic             pin_rise_i,
  input  logic             pin_fall_i,
  input  logic             dir_lvl_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             step_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] next_o
);
  logic tick_sel, ev, down;

  assign tick_sel = tick_i[psc_i];

  always_comb begin
    unique case (src_i)
      SRC_TICK:  ev = tick_sel;
      SRC_GATED: ev = tick_sel & (pin_lvl_i == gate_hi_i);
      SRC_EDGE:  ev = (edge_msk_i[0] & pin_rise_i) | (edge_msk_i[1] & pin_fall_i);
      default:   ev = 1'b0;
    endcase
  end

  assign down   = dir_dn_i ^ (xdir_en_i & dir_lvl_i);
  assign step_o = en_i & run_i & ev;
  assign wrap_o = step_o & (down ? (cnt_i == '0) : (&cnt_i));
  assign next_o = down ? cnt_i - 1'b1 : cnt_i + 1'b1;
endmodule

// File: rtl/mmt_timer.sv
module mmt_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W   = 16,  // at most REG_W
  parameter int NUM_AUX = 2,
  parameter int NUM     = NUM_AUX + 1,
  parameter int ADDR_W  = $clog2(2 * NUM + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              core_pin_i,
  input  logic              core_dir_i,
  input  logic [NUM_AUX-1:0] aux_pin_i,
  input  logic [NUM_AUX-1:0] aux_dir_i,
  output logic              tog_o,
  output logic [NUM-1:0]    irq_o
);
  localparam int FLAG_ADDR = 2 * NUM;
  localparam int TOG_BIT   = 8;

  tmr_ctrl_t        ctrl_q [NUM];
  logic [CNT_W-1:0] cnt_q  [NUM];
  logic [CNT_W-1:0] nxt    [NUM];
  logic [NUM-1:0]   step, wrap, wr_ctrl, wr_cnt, en;
  logic [NUM-1:0]   pin_lvl, pin_rise, pin_fall, dir_lvl;
  logic [NUM-1:0]   flag_q, flag_set, flag_clr;
  logic [NDIV-1:0]  tick;
  logic             tog_q, tog_rise, tog_fall, wr_flag;
  logic [NUM_AUX-1:0] cap_hit, rel_hit, rel_sel, aux_busy;
  logic [CNT_W-1:0] reload_val;
  logic [NUM*CNT_W-1:0] cnt_flat;

  logic [2*NUM-1:0] sy_lvl, sy_rise, sy_fall;

  mmt_sync_edge #(.N(2 * NUM)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({aux_dir_i, core_dir_i, aux_pin_i, core_pin_i}),
    .lvl_o  (sy_lvl),
    .rise_o (sy_rise),
    .fall_o (sy_fall)
  );

  assign pin_lvl  = sy_lvl[NUM-1:0];
  assign pin_rise = sy_rise[NUM-1:0];
  assign pin_fall = sy_fall[NUM-1:0];
  assign dir_lvl  = sy_lvl[2*NUM-1:NUM];

  mmt_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign wr_flag = we_i && (addr_i == ADDR_W'(FLAG_ADDR));

  for (genvar i = 0; i < NUM; i++) begin : g_tmr
    assign wr_ctrl[i] = we_i && (addr_i == ADDR_W'(2 * i));
    assign wr_cnt[i]  = we_i && (addr_i == ADDR_W'(2 * i + 1));
    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];

    if (i == 0) begin : g_core_en
      assign en[i] = 1'b1;
    end else begin : g_aux_en
      assign en[i] = (ctrl_q[i].role == ROLE_COUNT);
    end

    mmt_count_unit #(.CNT_W(CNT_W)) u_cu (
      .tick_i     (tick),
      .psc_i      (ctrl_q[i].psc),
      .src_i      (ctrl_q[i].src),
      .edge_msk_i (ctrl_q[i].edge_msk),
      .gate_hi_i  (ctrl_q[i].gate_hi),
      .dir_dn_i   (ctrl_q[i].dir_dn),
      .xdir_en_i  (ctrl_q[i].xdir_en),
      .run_i      (ctrl_q[i].run),
      .en_i       (en[i]),
      .pin_lvl_i  (pin_lvl[i]),
      .pin_rise_i (pin_rise[i]),
      .pin_fall_i (pin_fall[i]),
      .dir_lvl_i  (dir_lvl[i]),
      .cnt_i      (cnt_q[i]),
      .step_o     (step[i]),
      .wrap_o     (wrap[i]),
      .next_o     (nxt[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         ctrl_q[i] <= '0;
      else if (wr_ctrl[i]) ctrl_q[i] <= tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  // toggle flip direction of this cycle's wrap
  assign tog_rise = wrap[0] & ~tog_q;
  assign tog_fall = wrap[0] & tog_q;

  for (genvar k = 0; k < NUM_AUX; k++) begin : g_aux
    localparam int I = k + 1;
    assign aux_busy[k] = (ctrl_q[I].role == ROLE_CAPTURE) || (ctrl_q[I].role == ROLE_RELOAD);
    assign cap_hit[k]  = (ctrl_q[I].role == ROLE_CAPTURE) &&
                         ((ctrl_q[I].trig[0] & pin_rise[I]) | (ctrl_q[I].trig[1] & pin_fall[I]));
    assign rel_hit[k]  = (ctrl_q[I].role == ROLE_RELOAD) &&
                         ((ctrl_q[I].trig[0] & tog_rise) | (ctrl_q[I].trig[1] & tog_fall));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cnt_q[I] <= '0;
      else if (wr_cnt[I]) cnt_q[I] <= wdata_i[CNT_W-1:0];
      else if (cap_hit[k]) cnt_q[I] <= cnt_q[0];
      else if (step[I])   cnt_q[I] <= nxt[I];
    end

    assign flag_set[I] = wrap[I] | cap_hit[k];
  end

  // lowest-index reload source wins
  always_comb begin
    logic found;
    found      = 1'b0;
    reload_val = '0;
    for (int k = 0; k < NUM_AUX; k++) begin
      rel_sel[k] = rel_hit[k] & ~found;
      if (rel_sel[k]) reload_val = cnt_q[k+1];
      found = found | rel_hit[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q[0] <= '0;
    else if (wr_cnt[0]) cnt_q[0] <= wdata_i[CNT_W-1:0];
    else if (|rel_sel)  cnt_q[0] <= reload_val;
    else if (step[0])   cnt_q[0] <= nxt[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (wrap[0]) tog_q <= ~tog_q;
  end

  assign flag_set[0] = wrap[0];
  assign flag_clr    = wr_flag ? wdata_i[NUM-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (addr_i == ADDR_W'(2 * i))     rdata_o = REG_W'(ctrl_q[i]);
      if (addr_i == ADDR_W'(2 * i + 1)) rdata_o = REG_W'(cnt_flat[i*CNT_W +: CNT_W]);
    end
    if (addr_i == ADDR_W'(FLAG_ADDR)) begin
      rdata_o[NUM-1:0] = flag_q;
      rdata_o[TOG_BIT] = tog_q;
    end
  end

  assign tog_o = tog_q;
  assign irq_o = flag_q;
endmodule

// File: rtl/mmt_timer_chk.sv
module mmt_timer_chk #(
  parameter int CNT_W   = 16,
  parameter int NUM_AUX = 2,
  parameter int NUM     = NUM_AUX + 1,
  parameter int ADDR_W  = 3,
  parameter int REG_W   = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [REG_W-1:0]     wdata_i,
  input logic                 tog_o,
  input logic [NUM-1:0]       irq_o,
  input logic [NUM-1:0]       wrap,
  input logic [NUM_AUX-1:0]   cap_hit,
  input logic [NUM_AUX-1:0]   rel_sel,
  input logic [NUM_AUX-1:0]   aux_busy,
  input logic [NUM*CNT_W-1:0] cnt_flat
);
  localparam int FLAG_ADDR = 2 * NUM;

  logic wr_core;
  assign wr_core = we_i && (addr_i == ADDR_W'(1));

  a_r3_toggle_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[0] |=> (tog_o != $past(tog_o)));

  a_r3_toggle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap[0] |=> $stable(tog_o));

  a_r11_flag_set_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[0] |=> irq_o[0]);

  a_r11_flag_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o[0]) |-> $past(we_i && (addr_i == ADDR_W'(FLAG_ADDR)) && wdata_i[0]));

  a_r9_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rel_sel));

  for (genvar k = 0; k < NUM_AUX; k++) begin : g_chk
    localparam int I = k + 1;
    logic wr_aux;
    assign wr_aux = we_i && (addr_i == ADDR_W'(2 * I + 1));

    a_r8_capture_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_hit[k] && !wr_aux) |=>
        (cnt_flat[I*CNT_W +: CNT_W] == $past(cnt_flat[CNT_W-1:0])));

    a_r7_aux_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (aux_busy[k] && !cap_hit[k] && !wr_aux) |=> $stable(cnt_flat[I*CNT_W +: CNT_W]));

    a_r9_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_sel[k] && !wr_core) |=>
        (cnt_flat[CNT_W-1:0] == $past(cnt_flat[I*CNT_W +: CNT_W])));
  end
endmodule

bind mmt_timer mmt_timer_chk #(
  .CNT_W(CNT_W), .NUM_AUX(NUM_AUX), .NUM(NUM), .ADDR_W(ADDR_W), .REG_W(mmt_pkg::REG_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .tog_o    (tog_o),
  .irq_o    (irq_o),
  .wrap     (wrap),
  .cap_hit  (cap_hit),
  .rel_sel  (rel_sel),
  .aux_busy (aux_busy),
  .cnt_flat (cnt_flat)
);

// File: tb/mmt_timer_tb_top.sv
`timescale 1ns/1ps
module mmt_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        core_pin_i = 1'b0, core_dir_i = 1'b0;
  logic [1:0]  aux_pin_i = '0, aux_dir_i = '0;
  logic        tog_o;
  logic [2:0]  irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mmt_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .core_pin_i(core_pin_i), .core_dir_i(core_dir_i),
    .aux_pin_i(aux_pin_i), .aux_dir_i(aux_dir_i), .tog_o(tog_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [2:0]  n;
    logic        dn;
    logic [15:0] start;
    logic [7:0]  k;
    logic [15:0] expv;
    logic        wrap;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 16'h0010, 8'd5, 16'h0015, 1'b0},
    '{3'd1, 1'b0, 16'h1234, 8'd3, 16'h1237, 1'b0},
    '{3'd0, 1'b1, 16'h0003, 8'd5, 16'hFFFE, 1'b1},
    '{3'd2, 1'b1, 16'h8000, 8'd2, 16'h7FFE, 1'b0},
    '{3'd0, 1'b0, 16'hFFFE, 8'd4, 16'h0002, 1'b1},
    '{3'd3, 1'b0, 16'h0000, 8'd2, 16'h0002, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse_core();
    @(negedge clk_i); core_pin_i = 1'b1;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i); core_pin_i = 1'b0;
    repeat (4) @(posedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        t0;
    int          hi, lo, guard;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reset reg", v, 16'h0000);
    end
    check("R1 reset tog", {15'd0, tog_o}, 16'h0000);
    check("R1 reset irq", {13'd0, irq_o}, 16'h0000);

    // R2/R3/R6 vector walk on the main counter, source tick
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 16'h0000);
      wr(3'd1, VEC[i].start);
      wr(3'd6, 16'h0007);
      t0 = tog_o;
      wr(3'd0, 16'h0400 | (16'(VEC[i].dn) << 8) | 16'(VEC[i].n));
      repeat (int'(VEC[i].k) * (8 << VEC[i].n)) @(posedge clk_i);
      rd(3'd1, v);
      check("R2 tick count", v, VEC[i].expv);
      check("R3 toggle after wrap", {15'd0, tog_o}, {15'd0, t0 ^ VEC[i].wrap});
      check("R3 wrap flag", {15'd0, irq_o[0]}, {15'd0, VEC[i].wrap});
    end

    // R4 gated: pin low, gate active high -> no steps
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0100);
    wr(3'd0, 16'h0488);
    repeat (64) @(posedge clk_i);
    rd(3'd1, v);
    check("R4 gate closed", v, 16'h0100);
    @(negedge clk_i) core_pin_i = 1'b1;
    repeat (4) @(posedge clk_i);
    wr(3'd1, 16'h0000);
    repeat (32) @(posedge clk_i);
    rd(3'd1, v);
    check("R4 gate open", v, 16'h0004);
    @(negedge clk_i) core_pin_i = 1'b0;
    repeat (4) @(posedge clk_i);

    // R5 pin edges: rising, both, falling
    wr(3'd0, 16'h0430); wr(3'd1, 16'h0000);
    repeat (3) pulse_core();
    repeat (6) @(posedge clk_i);
    rd(3'd1, v); check("R5 rising edges", v, 16'h0003);
    wr(3'd0, 16'h0470); wr(3'd1, 16'h0000);
    repeat (3) pulse_core();
    repeat (6) @(posedge clk_i);
    rd(3'd1, v); check("R5 both edges", v, 16'h0006);
    wr(3'd0, 16'h0450); wr(3'd1, 16'h0000);
    repeat (2) pulse_core();
    repeat (6) @(posedge clk_i);
    rd(3'd1, v); check("R5 falling edges", v, 16'h0002);

    // R6 direction pin inverts software direction
    @(negedge clk_i) core_dir_i = 1'b1;
    repeat (4) @(posedge clk_i);
    wr(3'd0, 16'h0630); wr(3'd1, 16'h0000); wr(3'd6, 16'h0007);
    t0 = tog_o;
    repeat (2) pulse_core();
    repeat (6) @(posedge clk_i);
    rd(3'd1, v); check("R6 pin down", v, 16'hFFFE);
    check("R3 underflow toggle", {15'd0, tog_o}, {15'd0, ~t0});
    check("R3 underflow flag", {15'd0, irq_o[0]}, 16'h0001);
    wr(3'd0, 16'h0730); wr(3'd1, 16'h0010);
    repeat (2) pulse_core();
    repeat (6) @(posedge clk_i);
    rd(3'd1, v); check("R6 pin cancels sw down", v, 16'h0012);
    @(negedge clk_i) core_dir_i = 1'b0;

    // R11 write-one-to-clear
    wr(3'd0, 16'h0000);
    wr(3'd6, 16'h0002);
    check("R11 zero bit keeps flag", {15'd0, irq_o[0]}, 16'h0001);
    wr(3'd6, 16'h0001);
    check("R11 one bit clears flag", {15'd0, irq_o[0]}, 16'h0000);

    // R8/R7 capture by helper 1 (role capture, rising, run set)
    wr(3'd1, 16'h4321);
    wr(3'd2, 16'h2C00);
    @(negedge clk_i) aux_pin_i[0] = 1'b1;
    repeat (6) @(posedge clk_i);
    rd(3'd3, v); check("R8 captured value", v, 16'h4321);
    check("R8 capture flag", {15'd0, irq_o[1]}, 16'h0001);
    @(negedge clk_i) aux_pin_i[0] = 1'b0;
    repeat (100) @(posedge clk_i);
    rd(3'd3, v); check("R7 capture role frozen", v, 16'h4321);

    // R2 helper 2 in counter role
    wr(3'd4, 16'h0000); wr(3'd5, 16'h0100); wr(3'd4, 16'h0400);
    repeat (24) @(posedge clk_i);
    rd(3'd5, v); check("R2 helper tick count", v, 16'h0103);

    // R9/R10 PWM: helper 1 reload on rise from FFFC, helper 2 on fall from FFFE
    wr(3'd2, 16'h3000); wr(3'd3, 16'hFFFC);
    wr(3'd4, 16'h5000); wr(3'd5, 16'hFFFE);
    wr(3'd1, 16'hFFF0); wr(3'd0, 16'h0400);
    guard = 0;
    while (tog_o !== 1'b0 && guard < 2000) begin @(negedge clk_i); guard++; end
    while (tog_o !== 1'b1 && guard < 2000) begin @(negedge clk_i); guard++; end
    hi = 0;
    while (tog_o === 1'b1 && hi < 2000) begin @(negedge clk_i); hi++; end
    lo = 0;
    while (tog_o === 1'b0 && lo < 2000) begin @(negedge clk_i); lo++; end
    check("R10 high time", 16'(hi), 16'd32);
    check("R10 low time", 16'(lo), 16'd16);
    hi = 0;
    while (tog_o === 1'b1 && hi < 2000) begin @(negedge clk_i); hi++; end
    check("R9 repeat high time", 16'(hi), 16'd32);
    rd(3'd3, v); check("R7 reload role frozen", v, 16'hFFFC);

    // R9 priority: both helpers reload on any flip, helper 1 wins
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h7000); wr(3'd4, 16'h7000);
    wr(3'd3, 16'h0500); wr(3'd5, 16'h0900);
    wr(3'd1, 16'hFFFF);
    wr(3'd0, 16'h0400);
    repeat (8) @(posedge clk_i);
    rd(3'd1, v); check("R9 lower helper wins", v, 16'h0500);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule